// File: doc/BRIEF.md
# Converter Power-Up and Configuration Sequencer

This block runs on the host side of a data converter. After a start request it waits until the power-good input has been high for a programmed settling time. It then holds the converter's reset line high for a fixed width and waits a second fixed interval after reset is released. Finally it streams a list of 16-bit configuration words to the converter over a three-wire serial link: an active-low enable, a serial clock and a serial data line. All words go out back to back within one low period of the enable. Each word carries a 4-bit register address in its top nibble and 12 bits of register contents below it.

All three delays are given in nanoseconds together with the system clock frequency. Each delay becomes a whole number of system-clock cycles, rounded up. Every serial bit takes `SCLK_HALF` cycles with the clock high and `SCLK_HALF` cycles with it low. The data line changes only when the serial clock rises, so the converter can sample it on the falling edge.

The controller is a six-state machine:
- `ST_IDLE` moves to `ST_PWR_WAIT` on start.
- `ST_PWR_WAIT` moves to `ST_RST_PULSE` when the power wait ends.
- `ST_RST_PULSE` moves to `ST_WR_WAIT` when the pulse width ends.
- `ST_WR_WAIT` moves to `ST_SHIFT` when the write delay ends, or straight to `ST_DONE` when the word count is zero.
- `ST_SHIFT` moves to `ST_DONE` when the last word has been shifted.
- `ST_DONE` moves back to `ST_PWR_WAIT` on a new start.

Top module: `cnv_boot_seq`

## Requirements
- R1: After `rst_n` is released and before any start, `conv_rst`=0, `ser_en_n`=1, `ser_clk`=1, `ser_dat`=0, `seq_done`=0 and `seq_busy`=0.
- R2: Once a start is accepted, `conv_rst` rises on the PWR_CYC-th consecutive clock edge at which `pwr_good` is sampled high. A low sample of `pwr_good` during this wait restarts the count.
- R3: `conv_rst` stays high for exactly RST_CYC cycles, and there is exactly one pulse per sequence.
- R4: `ser_en_n` falls exactly WR_CYC cycles after `conv_rst` falls.
- R5: `ser_clk` is high whenever `ser_en_n` is high. While `ser_en_n` is low, `ser_dat` changes only in the cycle where `ser_clk` rises.
- R6: Words are sent MSB first. Word i is `cfg_words[16*i+15:16*i]`, with its address in bits 15:12. Word 0 is sent first, and all words are sent in one low period of `ser_en_n`. That low period lasts exactly count*32*SCLK_HALF cycles, where a `cfg_count` above NUM_WORDS is clamped to NUM_WORDS.
- R7: Each delay is ceil(ns*CLK_HZ/1e9) cycles. For example, 155 ns at 100 MHz gives 16 cycles and 201 ns gives 21 cycles.
- R8: `seq_done` rises one cycle after `ser_en_n` returns high and stays high until the next start. `seq_busy` is high from the accepted start until `seq_done` rises.
- R9: A start while `seq_busy` is high is ignored: no extra reset pulse, no extra frame and no extra bits.
- R10: With `cfg_count`=0 the reset phases still run, then `seq_done` rises and `ser_en_n` never falls.
- R11: A start while `seq_done` is high begins a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supplies-stable indication |
| start | input | 1 | Sequence request, one-cycle pulse |
| cfg_count | input | COUNT_W | Number of words to send |
| cfg_words | input | NUM_WORDS*16 | Word list, word 0 in the low 16 bits |
| conv_rst | output | 1 | Converter reset, active high |
| ser_en_n | output | 1 | Serial enable, active low |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data |
| seq_done | output | 1 | Sequence finished |
| seq_busy | output | 1 | Sequence in progress |

## Verification
The bench targets several boundaries, each with the failure it would expose:
- **Off-by-one delays.** Each phase length is timed to the exact cycle. A timer that stops one cycle early or late, or that truncates instead of rounding up, shifts the reset rise, the pulse width or the enable fall.
- **Glitch on `pwr_good`.** A one-cycle drop mid-wait must restart the count. A design that only pauses the count would assert reset too soon.
- **Word boundaries and enable release.** The captured words must match across the boundary between words. A design that drops the enable between words, or releases it before the final falling edge, loses bits.
- **Start while busy, zero count and clamping.** A start during a busy sequence must not produce a second reset pulse or frame. A zero count must produce no frame, and an oversized count must be clamped to NUM_WORDS.

// File: rtl/cnv_boot_pkg.sv
package cnv_boot_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR_WAIT,
        ST_RST_PULSE,
        ST_WR_WAIT,
        ST_SHIFT,
        ST_DONE
    } seq_state_t;

    // Round a delay in nanoseconds up to whole clock cycles, at least one.
    function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                     input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/cnv_phase_timer.sv
module cnv_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             phase_end
);

    logic [CNT_W-1:0] cnt_q;

    // The phase ends on the limit-th consecutive running cycle.
    assign phase_end = run && (cnt_q == (limit - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cnv_word_shifter.sv
module cnv_word_shifter
    import cnv_boot_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int SCLK_HALF = 2,
    parameter int COUNT_W   = $clog2(NUM_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic [COUNT_W-1:0]          n_words,
    input  logic [NUM_WORDS*WORD_W-1:0] words,
    output logic                        sen_n,
    output logic                        sclk,
    output logic                        sdata,
    output logic                        fin
);

    localparam int IDX_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int HALF_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] word_arr [NUM_WORDS];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WORDS; gi++) begin : g_words
            assign word_arr[gi] = words[gi*WORD_W +: WORD_W];
        end
    endgenerate

    logic              active_q;
    logic              low_q;
    logic [HALF_W-1:0] hcnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  widx_q;
    logic [WORD_W-1:0] shreg_q;
    logic [IDX_W-1:0]  nxt_idx;
    logic              last_word;
    logic              half_end;

    assign nxt_idx   = (widx_q == IDX_W'(NUM_WORDS - 1)) ? '0 : widx_q + IDX_W'(1);
    assign last_word = ((COUNT_W'(widx_q) + COUNT_W'(1)) == n_words);
    assign half_end  = (hcnt_q == HALF_W'(SCLK_HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            low_q    <= 1'b0;
            hcnt_q   <= '0;
            bit_q    <= '0;
            widx_q   <= '0;
            shreg_q  <= '0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                active_q <= 1'b1;
                low_q    <= 1'b0;
                hcnt_q   <= '0;
                bit_q    <= '0;
                widx_q   <= '0;
                shreg_q  <= word_arr[0];
            end else if (active_q) begin
                if (half_end) begin
                    hcnt_q <= '0;
                    low_q  <= !low_q;
                    if (low_q) begin
                        // Rising serial clock: advance to the next bit.
                        if (bit_q == BIT_W'(WORD_W - 1)) begin
                            bit_q <= '0;
                            if (last_word) begin
                                active_q <= 1'b0;
                                fin      <= 1'b1;
                                shreg_q  <= '0;
                            end else begin
                                widx_q  <= nxt_idx;
                                shreg_q <= word_arr[nxt_idx];
                            end
                        end else begin
                            bit_q   <= bit_q + BIT_W'(1);
                            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt_q <= hcnt_q + HALF_W'(1);
                end
            end
        end
    end

    assign sen_n = !active_q;
    assign sclk  = !(active_q && low_q);
    assign sdata = active_q && shreg_q[WORD_W-1];

endmodule

// File: rtl/cnv_boot_seq.sv
module cnv_boot_seq
    import cnv_boot_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 100_000_000,
    parameter longint unsigned PWR_WAIT_NS  = 10_000_000,
    parameter longint unsigned RST_WIDTH_NS = 2_000,
    parameter longint unsigned WR_WAIT_NS   = 2_000,
    parameter int              SCLK_HALF    = 2,
    parameter int              NUM_WORDS    = 4,
    parameter int              COUNT_W      = $clog2(NUM_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pwr_good,
    input  logic                        start,
    input  logic [COUNT_W-1:0]          cfg_count,
    input  logic [NUM_WORDS*WORD_W-1:0] cfg_words,
    output logic                        conv_rst,
    output logic                        ser_en_n,
    output logic                        ser_clk,
    output logic                        ser_dat,
    output logic                        seq_done,
    output logic                        seq_busy
);

    localparam int PWR_CYC = int'(ns_to_cycles(PWR_WAIT_NS, CLK_HZ));
    localparam int RST_CYC = int'(ns_to_cycles(RST_WIDTH_NS, CLK_HZ));
    localparam int WR_CYC  = int'(ns_to_cycles(WR_WAIT_NS, CLK_HZ));
    localparam int TMR_W   = $clog2(max3(PWR_CYC, RST_CYC, WR_CYC) + 1);

    seq_state_t         state_q, state_d;
    logic [COUNT_W-1:0] count_q;
    logic               tmr_run;
    logic [TMR_W-1:0]   tmr_limit;
    logic               tmr_end;
    logic               shift_go;
    logic               shift_fin;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Word count captured when a start is accepted, clamped to the list size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if ((state_q == ST_IDLE || state_q == ST_DONE) && start) begin
            count_q <= (cfg_count > COUNT_W'(NUM_WORDS)) ? COUNT_W'(NUM_WORDS) : cfg_count;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_PWR_WAIT;
            ST_PWR_WAIT:  if (tmr_end) state_d = ST_RST_PULSE;
            ST_RST_PULSE: if (tmr_end) state_d = ST_WR_WAIT;
            ST_WR_WAIT:   if (tmr_end) state_d = (count_q == '0) ? ST_DONE : ST_SHIFT;
            ST_SHIFT:     if (shift_fin) state_d = ST_DONE;
            ST_DONE:      if (start) state_d = ST_PWR_WAIT;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls decoded from the state.
    always_comb begin
        conv_rst  = 1'b0;
        seq_done  = 1'b0;
        seq_busy  = 1'b1;
        tmr_run   = 1'b0;
        tmr_limit = TMR_W'(1);
        shift_go  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                seq_busy = 1'b0;
            end
            ST_PWR_WAIT: begin
                tmr_run   = pwr_good;
                tmr_limit = TMR_W'(PWR_CYC);
            end
            ST_RST_PULSE: begin
                conv_rst  = 1'b1;
                tmr_run   = 1'b1;
                tmr_limit = TMR_W'(RST_CYC);
            end
            ST_WR_WAIT: begin
                tmr_run   = 1'b1;
                tmr_limit = TMR_W'(WR_CYC);
                shift_go  = tmr_end && (count_q != '0);
            end
            ST_SHIFT: begin
            end
            ST_DONE: begin
                seq_done = 1'b1;
                seq_busy = 1'b0;
            end
            default: begin
                seq_busy = 1'b0;
            end
        endcase
    end

    cnv_phase_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tmr_run),
        .limit     (tmr_limit),
        .phase_end (tmr_end)
    );

    cnv_word_shifter #(
        .NUM_WORDS (NUM_WORDS),
        .SCLK_HALF (SCLK_HALF),
        .COUNT_W   (COUNT_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (shift_go),
        .n_words (count_q),
        .words   (cfg_words),
        .sen_n   (ser_en_n),
        .sclk    (ser_clk),
        .sdata   (ser_dat),
        .fin     (shift_fin)
    );

endmodule

// File: rtl/cnv_boot_seq_chk.sv
module cnv_boot_seq_chk #(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 4,
    parameter int WR_CYC  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic conv_rst,
    input logic ser_en_n,
    input logic ser_clk,
    input logic ser_dat,
    input logic seq_done,
    input logic seq_busy
);

    logic [CNT_W-1:0] rst_run_q;
    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_run_q <= '0;
            gap_q     <= '0;
        end else begin
            rst_run_q <= conv_rst ? rst_run_q + CNT_W'(1) : '0;
            if (conv_rst) begin
                gap_q <= '0;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + CNT_W'(1);
            end
        end
    end

    assert_rst_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_rst) |-> (rst_run_q == CNT_W'(RST_CYC)));

    assert_write_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_en_n) |-> (gap_q == CNT_W'(WR_CYC)));

    assert_clk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en_n |-> ser_clk);

    assert_data_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en_n && $past(!ser_en_n) && !$stable(ser_dat)) |-> $rose(ser_clk));

    assert_no_rst_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rst |-> ser_en_n);

    assert_done_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> (ser_en_n && !seq_busy));

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(start));

    assert_done_busy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_busy));

endmodule

bind cnv_boot_seq cnv_boot_seq_chk #(
    .CNT_W   (TMR_W + 1),
    .RST_CYC (RST_CYC),
    .WR_CYC  (WR_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .conv_rst (conv_rst),
    .ser_en_n (ser_en_n),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .seq_done (seq_done),
    .seq_busy (seq_busy)
);

// File: tb/cnv_boot_seq_bench.sv
module cnv_boot_seq_bench;

    localparam int NW     = 4;
    localparam int HALF   = 2;
    localparam int CW     = $clog2(NW + 1);
    // Expected cycle counts at 100 MHz, rounded up (R7):
    // 1000 ns -> 100, 155 ns -> 16, 201 ns -> 21.
    localparam int EXP_P  = 100;
    localparam int EXP_R  = 16;
    localparam int EXP_W  = 21;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_good = 1'b0;
    logic             start = 1'b0;
    logic [CW-1:0]    cfg_count = '0;
    logic [NW*16-1:0] cfg_words = '0;
    logic conv_rst, ser_en_n, ser_clk, ser_dat, seq_done, seq_busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    cnv_boot_seq #(
        .CLK_HZ       (100_000_000),
        .PWR_WAIT_NS  (1000),
        .RST_WIDTH_NS (155),
        .WR_WAIT_NS   (201),
        .SCLK_HALF    (HALF),
        .NUM_WORDS    (NW)
    ) u_cnv_boot_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .start     (start),
        .cfg_count (cfg_count),
        .cfg_words (cfg_words),
        .conv_rst  (conv_rst),
        .ser_en_n  (ser_en_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .seq_done  (seq_done),
        .seq_busy  (seq_busy)
    );

    // Monitor, sampling on the falling clock edge.
    logic        mon_on = 1'b0;
    logic        p_rst, p_sen, p_clk, p_dat, p_done;
    int          t_rst_rise, t_rst_fall, t_sen_fall, t_sen_rise, t_done;
    int          rst_pulses, frames, nbits, viol, sen_low, ncap;
    logic [15:0] cap_sr;
    logic [15:0] cap_words [8];

    task automatic mon_clear();
        rst_pulses = 0; frames = 0; nbits = 0; viol = 0; sen_low = 0; ncap = 0;
        t_rst_rise = -1; t_rst_fall = -1; t_sen_fall = -1; t_sen_rise = -1; t_done = -1;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (conv_rst && !p_rst) begin t_rst_rise = cyc; rst_pulses++; end
            if (!conv_rst && p_rst) t_rst_fall = cyc;
            if (!ser_en_n && p_sen) begin t_sen_fall = cyc; frames++; end
            if (ser_en_n && !p_sen) t_sen_rise = cyc;
            if (seq_done && !p_done) t_done = cyc;
            if (!ser_en_n) sen_low++;
            if (ser_en_n && !ser_clk) viol++;
            if (!ser_clk && p_clk) begin
                if (ser_en_n) viol++;
                else begin
                    cap_sr = {cap_sr[14:0], ser_dat};
                    nbits++;
                    if (nbits % 16 == 0 && ncap < 8) begin
                        cap_words[ncap] = cap_sr;
                        ncap++;
                    end
                end
            end
            if (!ser_en_n && !p_sen && (ser_dat != p_dat) && !(ser_clk && !p_clk)) viol++;
        end
        p_rst = conv_rst; p_sen = ser_en_n; p_clk = ser_clk; p_dat = ser_dat; p_done = seq_done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        int ts;
        @(negedge clk);
        start = 1'b1;
        ts = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !seq_done; i++) @(negedge clk);
    endtask

    task automatic check_frame(input int cnt, input string tag);
        chk(frames == 1, {tag, " frame count"}, frames, 1);
        chk(nbits == 16 * cnt, {tag, " bit count"}, nbits, 16 * cnt);
        chk(sen_low == cnt * 32 * HALF, {tag, " enable low cycles"}, sen_low, cnt * 32 * HALF);
        for (int i = 0; i < cnt; i++)
            chk(cap_words[i] == cfg_words[i*16 +: 16], {tag, " word"},
                int'(cap_words[i]), int'(cfg_words[i*16 +: 16]));
    endtask

    // R1: idle outputs after reset.
    task automatic t_reset_state();
        chk(conv_rst == 1'b0, "R1 conv_rst", conv_rst, 0);
        chk(ser_en_n == 1'b1, "R1 ser_en_n", ser_en_n, 1);
        chk(ser_clk == 1'b1, "R1 ser_clk", ser_clk, 1);
        chk(ser_dat == 1'b0, "R1 ser_dat", ser_dat, 0);
        chk(seq_done == 1'b0 && seq_busy == 1'b0, "R1 done/busy", {seq_done, seq_busy}, 0);
    endtask

    // R2 R3 R4 R5 R6 R7 R8: full sequence with supplies already good.
    task automatic t_basic(input int cnt, input logic [NW*16-1:0] w, input string tag);
        int ts;
        mon_clear();
        pwr_good = 1'b1;
        cfg_count = CW'(cnt);
        cfg_words = w;
        @(negedge clk);
        start = 1'b1;
        ts = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(seq_busy == 1'b1, "R8 busy after start", seq_busy, 1);
        wait_done(5000);
        @(negedge clk);
        chk(t_rst_rise - ts == EXP_P + 1, "R2 power wait", t_rst_rise - ts, EXP_P + 1);
        chk(rst_pulses == 1, "R3 pulse count", rst_pulses, 1);
        chk(t_rst_fall - t_rst_rise == EXP_R, "R3 R7 reset width", t_rst_fall - t_rst_rise, EXP_R);
        chk(t_sen_fall - t_rst_fall == EXP_W, "R4 R7 write gap", t_sen_fall - t_rst_fall, EXP_W);
        chk(viol == 0, "R5 clock/data timing", viol, 0);
        check_frame(cnt, {"R6 ", tag});
        chk(t_done - t_sen_rise == 1, "R8 done timing", t_done - t_sen_rise, 1);
        chk(seq_done && !seq_busy, "R8 done held", {seq_done, seq_busy}, 2);
    endtask

    // R9: start pulses during a busy sequence are ignored.
    task automatic t_busy_start();
        mon_clear();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg_count = CW'(2);
        cfg_words = 64'h0000_0000_7E81_3C5A;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        for (int i = 0; i < 500 && !conv_rst; i++) @(negedge clk);
        pulse_start();
        for (int i = 0; i < 500 && ser_en_n; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        cfg_count = CW'(4);
        pulse_start();
        cfg_count = CW'(2);
        wait_done(5000);
        repeat (3) @(negedge clk);
        chk(rst_pulses == 1, "R9 single reset pulse", rst_pulses, 1);
        check_frame(2, "R9");
        chk(seq_done == 1'b1, "R9 done reached", seq_done, 1);
    endtask

    // R2: pwr_good low holds the wait; a one-cycle drop restarts it.
    task automatic t_pwr_restart();
        int tr;
        mon_clear();
        pwr_good = 1'b0;
        cfg_count = CW'(1);
        cfg_words = 64'h0000_0000_0000_9F0C;
        pulse_start();
        repeat (150) @(negedge clk);
        chk(rst_pulses == 0 && seq_busy, "R2 hold while power low", rst_pulses, 0);
        pwr_good = 1'b1;
        repeat (60) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        tr = cyc;
        wait_done(5000);
        @(negedge clk);
        chk(t_rst_rise - tr == EXP_P, "R2 restart after glitch", t_rst_rise - tr, EXP_P);
        check_frame(1, "R2");
    endtask

    // R10: zero word count produces no frame.
    task automatic t_zero();
        mon_clear();
        cfg_count = '0;
        pulse_start();
        wait_done(5000);
        repeat (3) @(negedge clk);
        chk(rst_pulses == 1, "R10 reset still pulsed", rst_pulses, 1);
        chk(frames == 0 && nbits == 0, "R10 no frame", frames + nbits, 0);
        chk(seq_done == 1'b1, "R10 done", seq_done, 1);
    endtask

    // R11 R6: start from done reruns; count above NW clamps to NW.
    task automatic t_restart_clamp();
        mon_clear();
        chk(seq_done == 1'b1, "R11 starts from done", seq_done, 1);
        cfg_count = CW'(5);
        cfg_words = 64'hF123_8ABC_40FF_1001;
        pulse_start();
        chk(seq_busy && !seq_done, "R11 busy again", {seq_busy, seq_done}, 2);
        wait_done(8000);
        @(negedge clk);
        chk(rst_pulses == 1, "R11 reset pulse", rst_pulses, 1);
        check_frame(NW, "R6 clamp");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        t_reset_state();
        t_basic(3, 64'h0000_2ABC_15A5_C3F0, "three words");
        t_basic(1, 64'h0000_0000_0000_A5C3, "one word");
        t_busy_start();
        t_pwr_restart();
        t_zero();
        t_restart_clamp();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule